// File: doc/BRIEF.md
# Ready-Controlled Wait-State Generator

This block stretches each external bus cycle by a number of wait states. A bus sequencer pulses a start strobe and presents a 3-bit wait code. The block captures the code, runs one access clock, and then inserts wait states. The code sets the most wait states allowed. An active-low ready input can end the waiting early. One code value has no upper limit, and only ready can end that wait.

The sequencer holds off while `stall` is high. It treats `cyc_done` as the end of the bus cycle. Codes that the encoding does not define are reported on `cfg_illegal`, and the cycle then runs as a zero-wait cycle.

The controller has four states:
- `ST_IDLE`: waiting for a start strobe.
- `ST_ACCESS`: the one base clock of every cycle.
- `ST_WAIT`: one clock per inserted wait state.
- `ST_DONE`: the single completion clock.

It has six transitions:
- accept: `ST_IDLE` to `ST_ACCESS`, on the start strobe.
- no-wait: `ST_ACCESS` to `ST_DONE`, when the limit is zero or ready is sampled high.
- stretch: `ST_ACCESS` to `ST_WAIT`.
- hold: `ST_WAIT` to `ST_WAIT`.
- release: `ST_WAIT` to `ST_DONE`, when ready is sampled high or the limit is used up.
- retire: `ST_DONE` to `ST_IDLE`.

Top module: `bus_wait_gen`

## Requirements
- R1: While reset is asserted and on the first clock after it, `stall`, `cyc_done` and `cfg_illegal` are all low.
- R2: A start strobe in `ST_IDLE` captures `wait_code`. The clock after that edge is the access clock. `cyc_done` is high for the clock that follows the last access or wait clock. With code 000 (bit2=0, bits1:0=00) no wait clock occurs, so `cyc_done` is high in the second clock after the capture edge.
- R3: Codes with bit2=1 and bits1:0 of 00, 01 or 10 allow at most bits1:0+1 wait clocks: one, two or three. `stall` is high during exactly those wait clocks.
- R4: Code 111 places no upper limit on the wait. Wait clocks continue for as long as ready is sampled low.
- R5: Ready is sampled at the end of the access clock and at the end of each wait clock. The first high sample ends the waiting at that edge. The number of wait clocks equals the number of low samples before the first high one, capped by the limit.
- R6: With a finite code, when the limit is reached and ready is still low, the cycle completes anyway after exactly the limit number of wait clocks.
- R7: Codes 001, 010 and 011 (bit2=0 with bits1:0 nonzero) are illegal. `cfg_illegal` is high from the access clock through the completion clock of that cycle. The cycle inserts no wait clock.
- R8: `cyc_done` lasts exactly one clock per cycle, and is never high in the same clock as `stall`.
- R9: A start strobe seen in the access, wait or completion clock is ignored. No extra cycle and no extra `cyc_done` follow from it.
- R10: `wait_code` is used only at the capture edge. Changing it during a cycle does not alter that cycle's wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cyc_start | input | 1 | Bus-cycle start strobe |
| wait_code | input | 3 | Wait code: bit2 enables waits, bits1:0 pick the limit, 11 means no limit |
| ready_i | input | 1 | Ready from the external device, high to end waits |
| stall | output | 1 | High during each inserted wait clock |
| cyc_done | output | 1 | One-clock pulse at the end of each bus cycle |
| cfg_illegal | output | 1 | The captured code is illegal |

## Verification
Two conditions can end the waiting at the same edge. Ready can be sampled high at the very edge where the programmed limit runs out. The bench provokes this by driving the first high ready sample exactly at the limit index for each finite code, both in directed cases and in random ones. The expected wait count is min(limit, first-high index), so the two conditions must agree, and the bench also checks that `cyc_done` follows after a single clock. Start strobes and code changes injected in the access and completion clocks test that a new request arriving alongside completion is dropped.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_WAIT   = 2'd2,
        ST_DONE   = 2'd3
    } bwg_state_e;

endpackage

// File: rtl/bwg_decode.sv
module bwg_decode #(
    parameter int CODE_W = 3,
    localparam int LOW_W = CODE_W - 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [LOW_W-1:0]  limit,
    output logic              infinite,
    output logic              illegal
);
    logic             enable;
    logic [LOW_W-1:0] low;

    always_comb begin
        enable   = code[CODE_W-1];
        low      = code[LOW_W-1:0];
        infinite = enable && (&low);
        illegal  = !enable && (|low);
        if (enable && !(&low)) begin
            limit = low + LOW_W'(1);
        end else begin
            limit = '0;
        end
    end
endmodule

// File: rtl/bwg_wait_counter.sv
module bwg_wait_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc && !(&count)) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/bwg_fsm.sv
module bwg_fsm
    import bwg_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ready,
    input  logic [CNT_W-1:0] limit,
    input  logic             infinite,
    input  logic [CNT_W-1:0] count,
    output bwg_state_e       state,
    output logic             capture,
    output logic             cnt_clear,
    output logic             cnt_inc,
    output logic             stall,
    output logic             done
);
    bwg_state_e state_q;
    bwg_state_e state_d;
    logic       limit_hit;
    logic       no_wait;

    always_comb begin
        limit_hit = !infinite && ({1'b0, count} + (CNT_W+1)'(1) == {1'b0, limit});
        no_wait   = !infinite && (limit == '0);
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ACCESS;
            ST_ACCESS: state_d = (no_wait || ready) ? ST_DONE : ST_WAIT;
            ST_WAIT:   if (ready || limit_hit) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        capture   = 1'b0;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        stall     = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   capture   = start;
            ST_ACCESS: cnt_clear = 1'b1;
            ST_WAIT: begin
                stall   = 1'b1;
                cnt_inc = 1'b1;
            end
            ST_DONE:   done      = 1'b1;
            default:   ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
    import bwg_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [CODE_W-1:0] wait_code,
    input  logic              ready_i,
    output logic              stall,
    output logic              cyc_done,
    output logic              cfg_illegal
);
    localparam int CNT_W = CODE_W - 1;

    bwg_state_e        state;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  lim_val;
    logic              lim_inf;
    logic              code_bad;
    logic [CNT_W-1:0]  wcount;
    logic              capture;
    logic              cnt_clear;
    logic              cnt_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (capture) begin
            code_q <= wait_code;
        end
    end

    bwg_decode #(.CODE_W(CODE_W)) u_decode (
        .code     (code_q),
        .limit    (lim_val),
        .infinite (lim_inf),
        .illegal  (code_bad)
    );

    bwg_wait_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .count (wcount)
    );

    bwg_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cyc_start),
        .ready     (ready_i),
        .limit     (lim_val),
        .infinite  (lim_inf),
        .count     (wcount),
        .state     (state),
        .capture   (capture),
        .cnt_clear (cnt_clear),
        .cnt_inc   (cnt_inc),
        .stall     (stall),
        .done      (cyc_done)
    );

    assign cfg_illegal = code_bad && (state != ST_IDLE);
endmodule

// File: rtl/bwg_checker.sv
module bwg_checker #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready_i,
    input logic             stall,
    input logic             cyc_done,
    input logic             cfg_illegal,
    input logic [CNT_W-1:0] lim_val,
    input logic             lim_inf
);
    logic [7:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else if (stall) begin
            if (run != 8'hFF) run <= run + 8'd1;
        end else begin
            run <= '0;
        end
    end

    // R3 and R6: the number of wait clocks in a row never exceeds a finite limit
    a_r3_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !lim_inf) |-> (run < 8'(lim_val)));

    // R5: a high ready sample during a wait clock ends the wait and completes the cycle
    a_r5_ready_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && ready_i) |=> (!stall && cyc_done));

    // R8: the completion pulse lasts one clock
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    // R8: stall and completion never coincide
    a_r8_done_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_done && stall));

    // R7: an illegal code never produces a wait clock
    a_r7_illegal_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_illegal |-> !stall);

    // R9: after completion the block is idle and not stalling
    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (!stall && !cfg_illegal));
endmodule

bind bus_wait_gen bwg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (ready_i),
    .stall       (stall),
    .cyc_done    (cyc_done),
    .cfg_illegal (cfg_illegal),
    .lim_val     (lim_val),
    .lim_inf     (lim_inf)
);

// File: tb/bus_wait_gen_test.sv
`timescale 1ns/100ps
module bus_wait_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic [2:0] wait_code = 3'd0;
    logic       ready_i = 1'b0;
    logic       stall;
    logic       cyc_done;
    logic       cfg_illegal;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_wait_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .wait_code   (wait_code),
        .ready_i     (ready_i),
        .stall       (stall),
        .cyc_done    (cyc_done),
        .cfg_illegal (cfg_illegal)
    );

    function automatic bit is_bad(input logic [2:0] c);
        return (c[2] == 1'b0) && (c[1:0] != 2'b00);
    endfunction

    function automatic int exp_waits(input logic [2:0] c, input int first_high);
        int lim;
        if (c[2] == 1'b0) return 0;
        if (c[1:0] == 2'b11) return first_high;
        lim = int'(c[1:0]) + 1;
        return (first_high < lim) ? first_high : lim;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle; first_high is the index of the first high ready sample.
    task automatic run_cycle(input logic [2:0] c, input int first_high, input bit noisy);
        int waits = 0;
        bit seen_done = 1'b0;
        bit bad = is_bad(c);
        @(negedge clk);
        cyc_start = 1'b1;
        wait_code = c;
        ready_i   = 1'b0;
        @(negedge clk);
        // access clock
        chk(stall == 1'b0 && cyc_done == 1'b0, "R2 access clock quiet", int'({stall, cyc_done}), 0);
        chk(cfg_illegal == bad, "R7 illegal flag in access clock", int'(cfg_illegal), int'(bad));
        ready_i   = (first_high == 0);
        cyc_start = noisy;            // R9 start in access clock
        wait_code = noisy ? 3'($urandom_range(0, 7)) : c;   // R10
        for (int n = 1; n < 60; n++) begin
            @(negedge clk);
            if (cyc_done) begin
                seen_done = 1'b1;
                break;
            end
            chk(stall == 1'b1, "R3 stall during wait", int'(stall), 1);
            waits++;
            ready_i   = (n >= first_high);
            cyc_start = noisy && ($urandom_range(0, 1) == 1);
            wait_code = 3'($urandom_range(0, 7));
        end
        chk(seen_done, "R2 cycle completes", int'(seen_done), 1);
        if (c[2] && c[1:0] == 2'b11)
            chk(waits == exp_waits(c, first_high), "R4 unbounded wait length", waits, exp_waits(c, first_high));
        else if (first_high >= int'(c[1:0]) + 1 && c[2])
            chk(waits == exp_waits(c, first_high), "R6 limit reached with ready low", waits, exp_waits(c, first_high));
        else
            chk(waits == exp_waits(c, first_high), "R5 wait count", waits, exp_waits(c, first_high));
        chk(stall == 1'b0, "R8 no stall with done", int'(stall), 0);
        chk(cfg_illegal == bad, "R7 illegal flag in completion clock", int'(cfg_illegal), int'(bad));
        cyc_start = noisy;            // R9 start in completion clock
        ready_i   = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        chk(cyc_done == 1'b0 && stall == 1'b0, "R8 done is a single pulse", int'(cyc_done), 0);
        @(negedge clk);
        chk(cyc_done == 1'b0 && cfg_illegal == 1'b0, "R9 ignored start makes no cycle", int'(cyc_done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(stall == 1'b0 && cyc_done == 1'b0 && cfg_illegal == 1'b0, "R1 reset outputs", int'({stall, cyc_done, cfg_illegal}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stall == 1'b0 && cyc_done == 1'b0 && cfg_illegal == 1'b0, "R1 after reset", int'({stall, cyc_done, cfg_illegal}), 0);

        // directed: R2 zero wait, R7 illegal codes
        run_cycle(3'b000, 9, 1'b0);
        run_cycle(3'b001, 9, 1'b0);
        run_cycle(3'b010, 0, 1'b1);
        run_cycle(3'b011, 9, 1'b1);
        // R3 and R6: each finite limit, ready never early
        for (int k = 4; k < 7; k++) run_cycle(3'(k), 20, 1'b0);
        // R5: ready ends early, and ready high exactly at the limit
        for (int k = 4; k < 7; k++) begin
            run_cycle(3'(k), 0, 1'b0);
            run_cycle(3'(k), k - 4, 1'b1);
            run_cycle(3'(k), k - 3, 1'b0);
        end
        // R4: unbounded wait
        run_cycle(3'b111, 0, 1'b0);
        run_cycle(3'b111, 17, 1'b1);
        // random mix
        for (int i = 0; i < 200; i++) begin
            logic [2:0] c = 3'($urandom_range(0, 7));
            int fh = (c == 3'b111) ? int'($urandom_range(0, 25)) : int'($urandom_range(0, 5));
            run_cycle(c, fh, $urandom_range(0, 1) == 1);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule